// File: doc/BRIEF.md
# Two-Wire Slave Register File

This block lets an external two-wire bus master read and write a small bank of 8-bit configuration registers. It watches SCL and SDA, sampling both on a fast system clock. It pulls SDA low through an open-drain enable when it acknowledges or sends a zero. Two strap pins choose which of four fixed 7-bit slave addresses the block answers to. Start, repeated start and stop conditions frame each transfer.

A write transfer carries the slave address, then a one-byte register pointer, then any number of data bytes. A read transfer is usually set up by writing only the pointer, issuing a repeated start, and then clocking data out. The pointer steps forward by one after every data byte in either direction.

One register address is a reset key. The value 0x12 followed by 0x34, written to that address with no other register write in between, returns every register to its default value.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges its own address followed by R/W = 0. The address is chosen by `addr_sel`: 00 gives 0x3E, 01 gives 0x3F, 10 gives 0x70 and 11 gives 0x71.
- R2: The block never acknowledges an address that is not its own, the general call address 0x00, or a 10-bit prefix (0b11110xx). It keeps SDA released for the rest of that transfer.
- R3: In a write, the slave address, the pointer byte and every data byte are each acknowledged. Each data byte is stored in the register named by the pointer.
- R4: The pointer increments by one after every data byte, whether written or read, and wraps from 0xFF to 0x00.
- R5: A repeated start after the pointer byte is accepted, and a read addressed with R/W = 1 then begins at that pointer.
- R6: Read data is shifted out MSB first and changes only while SCL is low. After the master NACKs a byte, SDA stays released until the next start.
- R7: Writing 0x12 and then 0x34 to the key address KEY_ADDR restores every register to its default. This works even when the two writes are in separate transfers.
- R8: The key is cancelled when any value other than 0x34 follows 0x12, or when any other address is written in between. A fresh 0x12 re-arms it. The key address reads back 0x00.
- R9: A stop at any point returns the block to idle, and a partly received byte is discarded.
- R10: After reset SDA is released, and register i holds its default value 0xA0 + i.
- R11: Addresses at or above NUM_REGS, other than KEY_ADDR, read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel | input | 2 | Strap pins that pick the slave address |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls SDA low |

## Verification
The bench builds the block with NUM_REGS = 12 and KEY_ADDR = 0x0C, so the key sits directly after the last storage register. With these values, a short auto-incrementing burst crosses storage, the key and unmapped space, and a burst started at 0xFF exercises the wrap to register 0. The key address also appears among randomly chosen write pointers, so random data can arm and fire the key, and the bench's model has to follow that.

// File: rtl/i2c_rf_pkg.sv
`timescale 1ns/1ps
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } rf_state_e;

  localparam logic [7:0] KEY_ARM  = 8'h12;
  localparam logic [7:0] KEY_FIRE = 8'h34;

  // strap pins to 7-bit slave address
  function automatic logic [6:0] dev_address(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'h3E;
      2'b01:   return 7'h3F;
      2'b10:   return 7'h70;
      default: return 7'h71;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int idx);
    return 8'hA0 + idx[7:0];
  endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
`timescale 1ns/1ps
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rf_regbank.sv
`timescale 1ns/1ps
module i2c_rf_regbank
  import i2c_rf_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter logic [7:0] KEY_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] regs [NUM_REGS];
  logic       armed;
  logic       key_fire;
  logic       wr_hit, rd_hit;

  assign wr_hit   = ({1'b0, wr_addr} < 9'(NUM_REGS)) && (wr_addr != KEY_ADDR);
  assign rd_hit   = ({1'b0, rd_addr} < 9'(NUM_REGS)) && (rd_addr != KEY_ADDR);
  assign key_fire = wr_en && (wr_addr == KEY_ADDR) && armed && (wr_data == KEY_FIRE);

  // key sequencer: any other write cancels, 0x12 (re)arms
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == KEY_ADDR) armed <= !key_fire && (wr_data == KEY_ARM);
      else                     armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || key_fire) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else if (wr_en && wr_hit) begin
      regs[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? regs[rd_addr[IDX_W-1:0]] : 8'h00;

  AST_KEY_RESTORES: assert property (@(posedge clk) disable iff (rst)
    key_fire |=> (regs[0] == reg_default(0))); // R7
  AST_KEY_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != KEY_ADDR) |=> !armed); // R8
endmodule

// File: rtl/i2c_regfile_slave.sv
`timescale 1ns/1ps
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter logic [7:0] KEY_ADDR    = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  output logic       sda_oe
);
  logic       scl_s, scl_rise, scl_fall;
  logic       sda_s, sda_rise, sda_fall;
  logic       start_det, stop_det;
  rf_state_e  state, nxt;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, ptr, rd_data;
  logic [6:0] my_addr;
  logic       nack;
  logic       wr_en;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_det = sda_fall && scl_s;
  assign stop_det  = sda_rise && scl_s;
  assign my_addr   = dev_address(addr_sel);
  assign wr_en     = (state == ST_WDATA) && scl_fall && (bit_cnt == 4'd8);

  i2c_rf_regbank #(.NUM_REGS(NUM_REGS), .KEY_ADDR(KEY_ADDR)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_addr(ptr), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      bit_cnt <= 4'd0;
      shreg   <= 8'h00;
      ptr     <= 8'h00;
      sda_oe  <= 1'b0;
      nack    <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= 4'd0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= 4'd0;
            case (state)
              ST_ADDR: begin
                if (shreg[7:1] == my_addr) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                  nxt    <= shreg[0] ? ST_RDATA : ST_PTR;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_PTR: begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                nxt    <= ST_WDATA;
              end
              default: begin
                ptr    <= ptr + 8'd1;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                nxt    <= ST_WDATA;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= 4'd0;
            state   <= nxt;
            if (nxt == ST_RDATA) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 8'd1;
              state  <= ST_RACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_IDLE;
            end else begin
              shreg   <= rd_data;
              sda_oe  <= ~rd_data[7];
              bit_cnt <= 4'd0;
              state   <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_RESET_RELEASED: assert property (@(posedge clk)
    rst |=> !sda_oe); // R10
  AST_NO_GENERAL_CALL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && shreg[7:1] == 7'd0) |=> !sda_oe); // R2
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe)); // R9
  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ptr == 8'($past(ptr) + 8'd1))); // R4
endmodule

// File: tb/test_i2c_regfile_slave.sv
`timescale 1ns/1ps
module test_i2c_regfile_slave;
  localparam int         NREG = 12;
  localparam logic [7:0] KEY  = 8'h0C;
  localparam int         Q    = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       sda_oe;
  logic       sda_line;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] model [0:255];
  logic       armed_m;
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regfile_slave #(.NUM_REGS(NREG), .KEY_ADDR(KEY), .SYNC_STAGES(2)) i_i2c_regfile_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe));

  function automatic logic [6:0] dev_of(input logic [1:0] s);
    case (s)
      2'b00:   return 7'h3E;
      2'b01:   return 7'h3F;
      2'b10:   return 7'h70;
      default: return 7'h71;
    endcase
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) model[i] = (i < NREG) ? 8'(8'hA0 + i) : 8'h00;
  endfunction

  function automatic void model_write(input logic [7:0] p, input logic [7:0] d);
    if (p == KEY) begin
      if (armed_m && d == 8'h34) begin
        model_reset();
        armed_m = 1'b0;
      end else begin
        armed_m = (d == 8'h12);
      end
    end else begin
      if (p < NREG) model[p] = d;
      armed_m = 1'b0;
    end
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick();
    scl = 1'b1;   tick();
    sda_m = 1'b0; tick();
    scl = 1'b0;   tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick();
    scl = 1'b1;   tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b;  tick();
    scl = 1'b1; tick();
    s = sda_line; tick();
    scl = 1'b0; tick();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic wr_xfer(input logic [7:0] p, input int n, output int acks);
    logic a;
    acks = 0;
    bus_start();
    send_byte({dev_of(sel), 1'b0}, a); acks += int'(a);
    send_byte(p, a);                   acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); acks += int'(a);
      model_write(8'(p + k), wbuf[k]);
    end
    bus_stop();
  endtask

  task automatic rd_xfer(input logic [7:0] p, input int n, output int acks);
    logic a;
    logic [7:0] d;
    acks = 0;
    bus_start();
    send_byte({dev_of(sel), 1'b0}, a); acks += int'(a);
    send_byte(p, a);                   acks += int'(a);
    bus_start();
    send_byte({dev_of(sel), 1'b1}, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      rbuf[k] = d;
    end
    bus_stop();
  endtask

  task automatic wr_one(input logic [7:0] p, input logic [7:0] d);
    int acks;
    wbuf[0] = d;
    wr_xfer(p, 1, acks);
  endtask

  task automatic rd_one(input logic [7:0] p, output logic [7:0] d);
    int acks;
    rd_xfer(p, 1, acks);
    d = rbuf[0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int acks;
    logic a, s;
    logic [7:0] d;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_reset();
    armed_m = 1'b0;

    repeat (4) @(posedge clk);
    #1;
    chk("R10", "sda_oe in reset", sda_oe, 1'b0);
    rst = 1'b0;
    tick();
    chk("R10", "sda_oe after reset", sda_oe, 1'b0);

    // R10 defaults, read as one burst through a repeated start (R5)
    rd_xfer(8'h00, NREG, acks);
    chk("R5", "acks of pointer-then-read", acks, 3);
    for (int k = 0; k < NREG; k++) chk("R10", "default value", rbuf[k], model[k]);

    // R1 / R2: address table per strap setting
    for (int s2 = 0; s2 < 4; s2++) begin
      sel = 2'(s2);
      tick();
      bus_start();
      send_byte({dev_of(sel), 1'b0}, a);
      chk("R1", "own address ack", a, 1'b1);
      bus_stop();
      bus_start();
      send_byte({dev_of(2'(s2 + 1)), 1'b0}, a);
      chk("R2", "foreign address ack", a, 1'b0);
      bus_stop();
    end
    sel = 2'b00;
    tick();

    // R2: general call and 10-bit prefix, slave stays silent afterwards
    bus_start();
    send_byte(8'h00, a);
    chk("R2", "general call ack", a, 1'b0);
    send_byte(8'h03, a);
    chk("R2", "byte after general call", a, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'hF0, a);
    chk("R2", "10-bit prefix ack", a, 1'b0);
    send_byte(8'h55, a);
    chk("R2", "byte after 10-bit prefix", a, 1'b0);
    bus_stop();

    // R3 / R4: burst write and read back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_xfer(8'h02, 3, acks);
    chk("R3", "write acks", acks, 5);
    rd_xfer(8'h02, 3, acks);
    for (int k = 0; k < 3; k++) chk("R4", "burst readback", rbuf[k], model[2 + k]);

    // R11: unmapped address
    wr_one(8'h20, 8'h77);
    rd_one(8'h20, d);
    chk("R11", "unmapped read", d, 8'h00);

    // R4 / R8 / R11: burst across last register, key and unmapped space
    wbuf[0] = 8'h5A; wbuf[1] = 8'h5B; wbuf[2] = 8'hC3; wbuf[3] = 8'h9D;
    wr_xfer(8'h0A, 4, acks);
    rd_xfer(8'h0A, 4, acks);
    chk("R4", "reg 0x0A", rbuf[0], 8'h5A);
    chk("R4", "reg 0x0B", rbuf[1], 8'h5B);
    chk("R8", "key reads zero", rbuf[2], 8'h00);
    chk("R11", "0x0D reads zero", rbuf[3], 8'h00);

    // R4: pointer wrap 0xFF -> 0x00
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    wr_xfer(8'hFF, 2, acks);
    rd_one(8'h00, d);
    chk("R4", "wrap to reg 0", d, 8'hE2);

    // R6: NACK releases SDA
    bus_start();
    send_byte({dev_of(sel), 1'b0}, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte({dev_of(sel), 1'b1}, a);
    recv_byte(1'b0, d);
    chk("R6", "read before nack", d, model[3]);
    recv_byte(1'b0, d);
    chk("R6", "line after nack", d, 8'hFF);
    bus_stop();

    // R9: stop part way through a data byte
    bus_start();
    send_byte({dev_of(sel), 1'b0}, a);
    send_byte(8'h05, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    bus_stop();
    rd_one(8'h05, d);
    chk("R9", "aborted byte not stored", d, model[5]);

    // R7: key in two transfers
    wr_one(KEY, 8'h12);
    wr_one(KEY, 8'h34);
    rd_xfer(8'h00, NREG, acks);
    for (int k = 0; k < NREG; k++) chk("R7", "restored default", rbuf[k], 8'(8'hA0 + k));

    // R8: cancellation and re-arm
    wr_one(8'h03, 8'h55);
    wr_one(KEY, 8'h12);
    wr_one(8'h04, 8'h66);
    wr_one(KEY, 8'h34);
    rd_one(8'h03, d);
    chk("R8", "other write cancels key", d, 8'h55);
    wr_one(KEY, 8'h12);
    wr_one(KEY, 8'h99);
    wr_one(KEY, 8'h34);
    rd_one(8'h04, d);
    chk("R8", "wrong value cancels key", d, 8'h66);
    wr_one(KEY, 8'h12);
    wr_one(KEY, 8'h12);
    wr_one(KEY, 8'h34);
    rd_one(8'h03, d);
    chk("R8", "re-armed key fires", d, 8'hA3);

    // R3 / R4: random bursts against the model
    for (int it = 0; it < 30; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom_range(0, 15));
      n = int'($urandom_range(1, 4));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_xfer(p, n, acks);
      chk("R3", "random write acks", acks, n + 2);
      rd_xfer(p, n, acks);
      for (int k = 0; k < n; k++) chk("R4", "random readback", rbuf[k], model[8'(p + k)]);
    end

    report();
    $finish;
  end
endmodule